// File: doc/BRIEF.md
# First-Fault Status Latch and Selector

This block watches four active-high health flags of a boost supply: power good, second-level supply undervoltage OK, thermal OK, and current-limit OK. A cancel control can force the current-limit flag to read as OK. The block keeps a sticky copy of each flag. The first flag that falls after the copies are armed is the only one recorded low, so the first cause of a shutdown can be read back afterwards. A raw operating-ready flag takes part in the live status.

A 3-bit select input chooses one signal to drive a single registered status bit. The choices are the live AND of all flags, the AND of the sticky copies, the raw ready flag, or one sticky copy. While the unit is in standby, or while the supply is below its first undervoltage threshold, the copies are cleared. A set input forces all copies to 1. A change of the 4-bit boost setpoint opens a short window. No capture takes place in that window, so a droop caused by the change is not recorded as a fault.

The copies have three phases. After a clear they track the live flags while ready is high. Once every copy reads 1 they are armed. The first falling edge then freezes them.

Top module: `first_fault_status`

## Requirements
- R1: With select 0, the status bit equals ready AND power-good AND undervoltage-OK AND thermal-OK AND (current-limit-OK OR cancel).
- R2: Select 1 gives the AND of the four sticky copies. Select 2 gives raw ready. Selects 3, 4, 6 and 7 give the sticky copy of power-good, undervoltage-OK, thermal-OK and (current-limit-OK OR cancel), in that order.
- R3: Select 5 drives the status bit low.
- R4: The status bit is registered. It reflects the select and the inputs of the previous clock edge, and it reads 0 during and right after the asynchronous active-low reset.
- R5: When the copies are armed (all 1) and exactly one health flag falls from 1 to 0, only that flag's copy goes to 0. The other copies stay at 1.
- R6: When several health flags fall in the same cycle while the copies are armed, all of their copies go to 0 together.
- R7: Once any copy has been captured low, later falls and recoveries of any flag leave every copy unchanged until a clear or a set.
- R8: While standby or low supply is 1, all copies are forced to 0 and the block returns to tracking. This has priority over set.
- R9: While set is 1 and no clear is active, all copies are forced to 1 and the block is armed. This has priority over the setpoint mask.
- R10: When the setpoint differs from its value at the previous edge, the copies hold for that cycle and for the next 8 cycles. A flag that falls in this window and stays low is not captured afterwards. A fall after the window is captured.
- R11: After a clear, each copy equals its live flag while ready is 1, and reads 0 while ready is 0. The copies arm in the cycle all four live flags and ready are 1.
- R12: A current-limit fall while cancel is 1 is neither seen by select 0 nor captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Standby mode; clears the copies |
| vcc_low_i | input | 1 | Supply below first undervoltage threshold; clears the copies |
| set_i | input | 1 | Forces all copies to 1 |
| ready_i | input | 1 | Raw operating-ready flag |
| pgood_i | input | 1 | Power good, 1 = OK |
| uv2_ok_i | input | 1 | Second-level undervoltage OK, 1 = OK |
| therm_ok_i | input | 1 | Thermal OK, 1 = OK |
| ilim_ok_i | input | 1 | Current-limit OK, 1 = OK |
| ilim_cancel_i | input | 1 | Makes the current-limit flag read as OK |
| setpoint_i | input | 4 | Boost setpoint; any change opens the capture mask |
| sel_i | input | 3 | Status source select |
| status_o | output | 1 | Registered status bit |

## Verification
The bench targets five corner cases.

A single fault followed by a second fault must leave only the first copy low. A design that keeps capturing after the first fault would show both copies low on selects 3 to 7.

Two flags dropping in the same cycle must both be recorded. A design that applies a priority would drop one of them.

A flag that falls inside the setpoint window and stays low must not be captured later. A level-based capture would record it once the window closes. A capture on the last cycle of the window would show a counter that is off by one.

The bench also checks the priority order of clear, set and mask, and checks that cancel hides a current-limit drop.

// File: rtl/first_fault_pkg.sv
package first_fault_pkg;
  localparam int unsigned NUM_FLAGS = 4;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned SP_W      = 4;
  localparam int unsigned MASK_CYC  = 8;

  // bit positions in the health vector
  localparam int unsigned HB_PG = 3;
  localparam int unsigned HB_UV = 2;
  localparam int unsigned HB_TH = 1;
  localparam int unsigned HB_IL = 0;

  typedef logic [NUM_FLAGS-1:0] health_t;

  typedef enum logic [1:0] {
    LM_TRACK  = 2'd0,
    LM_ARMED  = 2'd1,
    LM_FROZEN = 2'd2
  } latch_mode_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_LIVE_AND = 3'd0,
    SEL_LAT_AND  = 3'd1,
    SEL_READY    = 3'd2,
    SEL_LAT_PG   = 3'd3,
    SEL_LAT_UV   = 3'd4,
    SEL_NONE     = 3'd5,
    SEL_LAT_TH   = 3'd6,
    SEL_LAT_IL   = 3'd7
  } status_sel_e;
endpackage

// File: rtl/health_edge.sv
module health_edge
  import first_fault_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  health_t health_i,
  output health_t fall_o
);
  health_t prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= health_i;
  end

  assign fall_o = prev_q & ~health_i;
endmodule

// File: rtl/setpoint_mask.sv
module setpoint_mask #(
  parameter int unsigned SPW   = 4,
  parameter int unsigned CYCLES = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [SPW-1:0] setpoint_i,
  output logic           mask_o
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CYCLES);

  logic [SPW-1:0]   sp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             changed;

  assign changed = (setpoint_i != sp_q);
  assign mask_o  = changed || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      cnt_q <= '0;
    end else begin
      sp_q <= setpoint_i;
      if (changed)            cnt_q <= CNT_LOAD;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/first_fault_core.sv
module first_fault_core
  import first_fault_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear_i,
  input  logic        set_i,
  input  logic        mask_i,
  input  logic        ready_i,
  input  health_t     health_i,
  input  health_t     fall_i,
  output health_t     lat_o,
  output latch_mode_e mode_o
);
  health_t     lat_q, lat_d;
  latch_mode_e mode_q, mode_d;

  always_comb begin
    lat_d  = lat_q;
    mode_d = mode_q;
    if (clear_i) begin
      lat_d  = '0;
      mode_d = LM_TRACK;
    end else if (set_i) begin
      lat_d  = '1;
      mode_d = LM_ARMED;
    end else if (!mask_i) begin
      unique case (mode_q)
        LM_TRACK: begin
          lat_d = ready_i ? health_i : '0;
          if (ready_i && (&health_i)) mode_d = LM_ARMED;
        end
        LM_ARMED: begin
          if (fall_i != '0) begin
            lat_d  = lat_q & ~fall_i;
            mode_d = LM_FROZEN;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      mode_q <= LM_TRACK;
    end else begin
      lat_q  <= lat_d;
      mode_q <= mode_d;
    end
  end

  assign lat_o  = lat_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/status_select.sv
module status_select
  import first_fault_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             ready_i,
  input  health_t          health_i,
  input  health_t          lat_i,
  output logic             status_o
);
  logic pick;

  always_comb begin
    unique case (status_sel_e'(sel_i))
      SEL_LIVE_AND: pick = ready_i & (&health_i);
      SEL_LAT_AND:  pick = &lat_i;
      SEL_READY:    pick = ready_i;
      SEL_LAT_PG:   pick = lat_i[HB_PG];
      SEL_LAT_UV:   pick = lat_i[HB_UV];
      SEL_LAT_TH:   pick = lat_i[HB_TH];
      SEL_LAT_IL:   pick = lat_i[HB_IL];
      default:      pick = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_o <= 1'b0;
    else        status_o <= pick;
  end
endmodule

// File: rtl/first_fault_status.sv
module first_fault_status
  import first_fault_pkg::*;
#(
  parameter int unsigned SETPOINT_W  = SP_W,
  parameter int unsigned MASK_CYCLES = MASK_CYC
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  standby_i,
  input  logic                  vcc_low_i,
  input  logic                  set_i,
  input  logic                  ready_i,
  input  logic                  pgood_i,
  input  logic                  uv2_ok_i,
  input  logic                  therm_ok_i,
  input  logic                  ilim_ok_i,
  input  logic                  ilim_cancel_i,
  input  logic [SETPOINT_W-1:0] setpoint_i,
  input  logic [SEL_W-1:0]      sel_i,
  output logic                  status_o
);
  health_t     health_w;
  health_t     fall_w;
  health_t     lat_w;
  latch_mode_e mode_w;
  logic        mask_w;
  logic        clear_w;

  always_comb begin
    health_w        = '0;
    health_w[HB_PG] = pgood_i;
    health_w[HB_UV] = uv2_ok_i;
    health_w[HB_TH] = therm_ok_i;
    health_w[HB_IL] = ilim_ok_i | ilim_cancel_i;
  end

  assign clear_w = standby_i | vcc_low_i;

  health_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .health_i (health_w),
    .fall_o   (fall_w)
  );

  setpoint_mask #(
    .SPW    (SETPOINT_W),
    .CYCLES (MASK_CYCLES)
  ) u_mask (
    .clk        (clk),
    .rst_n      (rst_n),
    .setpoint_i (setpoint_i),
    .mask_o     (mask_w)
  );

  first_fault_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (clear_w),
    .set_i    (set_i),
    .mask_i   (mask_w),
    .ready_i  (ready_i),
    .health_i (health_w),
    .fall_i   (fall_w),
    .lat_o    (lat_w),
    .mode_o   (mode_w)
  );

  status_select u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_i    (sel_i),
    .ready_i  (ready_i),
    .health_i (health_w),
    .lat_i    (lat_w),
    .status_o (status_o)
  );
endmodule

// File: rtl/first_fault_checker.sv
module first_fault_checker
  import first_fault_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             standby_i,
  input logic             vcc_low_i,
  input logic             set_i,
  input logic [SEL_W-1:0] sel_i,
  input logic             status_o,
  input health_t          lat,
  input logic [1:0]       mode,
  input logic             mask
);
  a_r3_sel5_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == 3'd5) |=> !status_o);

  a_r2_lat_and: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == 3'd1) |=> (status_o == (&$past(lat))));

  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_i || vcc_low_i) |=> (lat == '0));

  a_r9_set_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby_i && !vcc_low_i && set_i) |=> (lat == '1));

  a_r7_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LM_FROZEN && !standby_i && !vcc_low_i && !set_i) |=> $stable(lat));

  a_r10_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mask && !standby_i && !vcc_low_i && !set_i) |=> $stable(lat));

  a_r5_armed_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LM_ARMED) |-> (lat == '1));
endmodule

bind first_fault_status first_fault_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .standby_i (standby_i),
  .vcc_low_i (vcc_low_i),
  .set_i     (set_i),
  .sel_i     (sel_i),
  .status_o  (status_o),
  .lat       (lat_w),
  .mode      (mode_w),
  .mask      (mask_w)
);

// File: tb/first_fault_status_tb.sv
module first_fault_status_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       standby_i = 1'b0, vcc_low_i = 1'b0, set_i = 1'b0, ready_i = 1'b0;
  logic       pgood_i = 1'b0, uv2_ok_i = 1'b0, therm_ok_i = 1'b0, ilim_ok_i = 1'b0;
  logic       ilim_cancel_i = 1'b0;
  logic [3:0] setpoint_i = 4'd0;
  logic [2:0] sel_i = 3'd0;
  logic       status_o;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string phase = "R4";

  always #10 clk = ~clk;

  first_fault_status u_dut (
    .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .vcc_low_i(vcc_low_i),
    .set_i(set_i), .ready_i(ready_i), .pgood_i(pgood_i), .uv2_ok_i(uv2_ok_i),
    .therm_ok_i(therm_ok_i), .ilim_ok_i(ilim_ok_i), .ilim_cancel_i(ilim_cancel_i),
    .setpoint_i(setpoint_i), .sel_i(sel_i), .status_o(status_o)
  );

  // reference model: index 0 pg, 1 uv, 2 th, 3 il
  bit m_lat[4];
  bit m_prev[4];
  int m_mode;    // 0 tracking, 1 armed, 2 frozen
  int m_sp;
  int m_win;
  bit m_out;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin m_lat[i] = 0; m_prev[i] = 0; end
      m_mode = 0; m_sp = 0; m_win = 0; m_out = 0;
    end else begin
      bit h[4];
      bit fell;
      bit all_h;
      bit masked;
      h[0] = pgood_i; h[1] = uv2_ok_i; h[2] = therm_ok_i; h[3] = ilim_ok_i | ilim_cancel_i;
      all_h = h[0] && h[1] && h[2] && h[3];
      case (sel_i)
        3'd0: m_out = ready_i && all_h;
        3'd1: m_out = m_lat[0] && m_lat[1] && m_lat[2] && m_lat[3];
        3'd2: m_out = ready_i;
        3'd3: m_out = m_lat[0];
        3'd4: m_out = m_lat[1];
        3'd6: m_out = m_lat[2];
        3'd7: m_out = m_lat[3];
        default: m_out = 0;
      endcase
      masked = (int'(setpoint_i) != m_sp) || (m_win > 0);
      if (standby_i || vcc_low_i) begin
        for (int i = 0; i < 4; i++) m_lat[i] = 0;
        m_mode = 0;
      end else if (set_i) begin
        for (int i = 0; i < 4; i++) m_lat[i] = 1;
        m_mode = 1;
      end else if (!masked) begin
        if (m_mode == 0) begin
          for (int i = 0; i < 4; i++) m_lat[i] = ready_i && h[i];
          if (ready_i && all_h) m_mode = 1;
        end else if (m_mode == 1) begin
          fell = 0;
          for (int i = 0; i < 4; i++) if (m_prev[i] && !h[i]) begin m_lat[i] = 0; fell = 1; end
          if (fell) m_mode = 2;
        end
      end
      if (int'(setpoint_i) != m_sp) m_win = 8;
      else if (m_win > 0) m_win--;
      m_sp = int'(setpoint_i);
      for (int i = 0; i < 4; i++) m_prev[i] = h[i];
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      checks++;
      if (status_o !== m_out) begin
        errors++;
        $display("FAIL %s: cycle %0d sel %0d status actual %0b expected %0b",
                 phase, cycles, sel_i, status_o, m_out);
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // point a selector at a signal and compare to a hand-derived value
  task automatic peek(input logic [2:0] s, input bit exp, input string tag);
    sel_i = s;
    wait_n(2);
    checks++;
    if (status_o !== exp) begin
      errors++;
      $display("FAIL %s: sel %0d actual %0b expected %0b", tag, s, status_o, exp);
    end
  endtask

  task automatic all_ok();
    pgood_i = 1; uv2_ok_i = 1; therm_ok_i = 1; ilim_ok_i = 1;
  endtask

  initial begin
    // R4: reset value
    wait_n(2);
    checks++;
    if (status_o !== 1'b0) begin
      errors++;
      $display("FAIL R4: reset status actual %0b expected 0", status_o);
    end
    rst_n = 1;
    wait_n(2);

    // R11: tracking with power-good still low
    phase = "R11";
    ready_i = 1; uv2_ok_i = 1; therm_ok_i = 1; ilim_ok_i = 1;
    wait_n(1);
    peek(3'd3, 0, "R11 pg copy follows low");
    peek(3'd4, 1, "R11 uv copy reads 1 with ready");
    pgood_i = 1;
    wait_n(1);
    peek(3'd1, 1, "R11 armed");
    phase = "R1";
    peek(3'd0, 1, "R1 live AND high");
    peek(3'd2, 1, "R2 ready");
    phase = "R3";
    peek(3'd5, 0, "R3 unused code low");

    // R5: single fault, R7 later faults ignored
    phase = "R5";
    therm_ok_i = 0;
    wait_n(1);
    peek(3'd6, 0, "R5 thermal captured");
    peek(3'd3, 1, "R5 pg stays 1");
    peek(3'd7, 1, "R5 ilim stays 1");
    peek(3'd0, 0, "R1 live AND low");
    phase = "R7";
    pgood_i = 0;
    wait_n(2);
    peek(3'd3, 1, "R7 later pg fault ignored");
    all_ok();
    wait_n(2);
    peek(3'd6, 0, "R7 recovery ignored");
    peek(3'd1, 0, "R2 latched AND low");

    // R8: standby clear and re-arm
    phase = "R8";
    standby_i = 1;
    wait_n(1);
    peek(3'd4, 0, "R8 standby clears");
    standby_i = 0;
    wait_n(1);
    peek(3'd1, 1, "R11 re-armed after clear");

    // R6: simultaneous falls
    phase = "R6";
    uv2_ok_i = 0; ilim_ok_i = 0;
    wait_n(1);
    peek(3'd4, 0, "R6 uv captured");
    peek(3'd7, 0, "R6 ilim captured");
    peek(3'd3, 1, "R6 pg stays 1");
    peek(3'd6, 1, "R6 thermal stays 1");

    // R9: set, and clear priority over set
    phase = "R9";
    all_ok();
    set_i = 1;
    wait_n(1);
    peek(3'd1, 1, "R9 set forces ones");
    standby_i = 1;
    wait_n(1);
    peek(3'd1, 0, "R8 clear beats set");
    standby_i = 0;
    wait_n(1);
    set_i = 0;
    wait_n(2);

    // R12: cancel hides a current-limit drop
    phase = "R12";
    ilim_cancel_i = 1; ilim_ok_i = 0;
    wait_n(2);
    peek(3'd7, 1, "R12 not captured");
    peek(3'd0, 1, "R12 live AND ignores ilim");
    ilim_ok_i = 1;
    wait_n(1);
    ilim_cancel_i = 0;
    wait_n(2);

    // R10: setpoint mask window
    phase = "R10";
    setpoint_i = 4'd5;
    wait_n(1);
    pgood_i = 0;
    wait_n(12);
    peek(3'd3, 1, "R10 fall in window not captured");
    pgood_i = 1;
    wait_n(2);
    setpoint_i = 4'd9;
    wait_n(9);
    therm_ok_i = 0;
    wait_n(1);
    peek(3'd6, 0, "R10 fall after window captured");
    therm_ok_i = 1;

    // R8: low supply clears
    phase = "R8";
    vcc_low_i = 1;
    wait_n(1);
    peek(3'd1, 0, "R8 low supply clears");
    ready_i = 0;
    vcc_low_i = 0;
    wait_n(1);
    peek(3'd4, 0, "R11 copy 0 without ready");
    ready_i = 1;
    wait_n(1);
    peek(3'd1, 1, "R11 arms with ready");
    wait_n(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_n(100000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, actual hang expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule